// File: doc/BRIEF.md
# HDLC Receive Deframer with FCS and Length Checking

This block turns a serial HDLC line into bytes. It watches the raw bit stream, qualified by a bit enable, for the 0x7E flag. It strips the zero bits that the sender inserted for transparency and packs the remaining bits into bytes, least significant bit first. The frame check sequence is verified with either the 16-bit CCITT polynomial or the 32-bit polynomial. A run-time select input picks the polynomial.

Each frame comes out as a stream of bytes on a one-cycle strobe. The FCS bytes are removed from that stream. The first byte of a frame carries a start marker. The last payload byte carries an end marker and a 3-bit status code. A frame can be rejected for a bad CRC, a payload length outside a programmable window, an abort sequence on the line, or a bit count that is not a whole number of octets. Fragments too short to hold an FCS plus one byte are dropped without any output.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `out_sof`, `out_eof` and `out_err` are all 0, and the block is hunting: no byte is produced until a flag has been seen.
- R2: A flag is the raw sequence 0,1,1,1,1,1,1,0. Bits received before the first flag, and bits received while hunting after an abort, produce no output.
- R3: A raw 0 that follows exactly five consecutive raw 1s is discarded before byte assembly.
- R4: Destuffed bits are packed least significant bit first. The output is every frame byte except the trailing FCS bytes, which are 2 bytes when `crc32_sel`=0 and 4 bytes when `crc32_sel`=1.
- R5: The first output byte of a frame has `out_sof`=1. The last payload byte has `out_eof`=1. A frame of exactly one payload byte has both flags on the same strobe.
- R6: With `crc32_sel`=0, a CRC-CCITT residue (reflected polynomial 0x8408, preset all ones) other than 0xF0B8 at the closing flag gives `out_err`=1 (CRC). A good frame gives `out_err`=0.
- R7: With `crc32_sel`=1, the CRC-32 residue (reflected polynomial 0xEDB88320, preset all ones) must equal 0xDEBB20E3, otherwise `out_err`=1.
- R8: If the payload byte count (FCS excluded) is below `min_len` or above `max_len`, and the CRC is good, `out_err`=2 (length). A CRC error takes priority over a length error.
- R9: Seven or more consecutive raw 1s form an abort. If at least one byte of the frame has been assembled, the oldest byte still withheld is emitted with `out_eof`=1 and `out_err`=3. The block then hunts for a flag.
- R10: If the closing flag arrives when the bit count is not a multiple of 8, `out_err`=4 (alignment). This code takes priority over CRC and length errors. No other code value is ever produced.
- R11: A frame with fewer than FCS length + 1 complete bytes between two flags produces no output at all.
- R12: One flag both closes a frame and opens the next. Cycles with `bit_en`=0 change nothing.
- R13: Any output strobe appears exactly two clock cycles after the `bit_en` cycle of the raw bit that caused it. A data bit is released for assembly seven raw bits after it arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Raw serial line bit |
| crc32_sel | input | 1 | 0: 16-bit CCITT FCS, 1: 32-bit FCS |
| min_len | input | LEN_W (16) | Smallest accepted payload byte count |
| max_len | input | LEN_W (16) | Largest accepted payload byte count |
| out_valid | output | 1 | Byte strobe |
| out_data | output | 8 | Payload byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last payload byte of a frame |
| out_err | output | 3 | Status on the end byte: 0 ok, 1 CRC, 2 length, 3 abort, 4 alignment |

## Verification
The sensitive collision is the closing flag of one frame serving as the opening flag of the next. In that single cycle, the end strobe with its status is emitted while the byte packer, CRC registers and withheld-byte store are all reset for the new frame. The bench provokes this with back-to-back frames that share one flag, and it inserts idle `bit_en` gaps inside them. It judges the result by requiring a correct end status on the first frame, and a fresh start marker and good CRC on the second. A behavioural model written independently of the RTL predicts every clock's strobe, byte and status, and each of these is compared against the design. Stuffing is forced with payload bytes of 0x7E and 0xFF, which also places stuffed zeros across byte boundaries.

// File: rtl/hdlc_rx_pkg.sv
// Shared constants and status codes for the HDLC receive deframer.
package hdlc_rx_pkg;
    typedef enum logic [2:0] {
        ST_OK    = 3'd0,
        ST_CRC   = 3'd1,
        ST_LEN   = 3'd2,
        ST_ABORT = 3'd3,
        ST_ALIGN = 3'd4
    } rx_status_e;

    localparam int unsigned FLAG_BITS = 8;
    localparam logic [15:0] CCITT_POLY = 16'h8408;
    localparam logic [15:0] CCITT_GOOD = 16'hF0B8;
    localparam logic [31:0] C32_POLY   = 32'hEDB88320;
    localparam logic [31:0] C32_GOOD   = 32'hDEBB20E3;
endpackage

// File: rtl/hdlc_rx_destuff.sv
// Raw-line front end. It counts consecutive ones to spot flags, aborts and
// stuffed zeros, and holds bits in a short delay line so that the bits of
// a flag can be cancelled before they are released as data.
// Assumes: at most one raw bit per cycle (bit_en). Each cycle produces at most
// one of data-bit, flag or abort, registered one cycle after bit_en.
module hdlc_rx_destuff
    import hdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    output logic d_valid,
    output logic d_bit,
    output logic flag_seen,
    output logic abort_seen
);
    localparam int unsigned LINE = FLAG_BITS - 1;

    logic [2:0]      ones;
    logic [LINE-1:0] ln_bit;
    logic [LINE-1:0] ln_keep;
    logic            is_flag, is_abort, is_stuff;

    // classify the current raw bit against the preceding run of ones
    always_comb begin
        is_flag  = bit_en && !bit_in && (ones == 3'd6);
        is_abort = bit_en &&  bit_in && (ones >= 3'd6);
        is_stuff = bit_en && !bit_in && (ones == 3'd5);
    end

    // run counter, delay line and registered event outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones       <= '0;
            ln_bit     <= '0;
            ln_keep    <= '0;
            d_valid    <= 1'b0;
            d_bit      <= 1'b0;
            flag_seen  <= 1'b0;
            abort_seen <= 1'b0;
        end else begin
            d_valid    <= 1'b0;
            flag_seen  <= 1'b0;
            abort_seen <= 1'b0;
            if (bit_en) begin
                ones <= bit_in ? ((ones == 3'd7) ? 3'd7 : ones + 3'd1) : 3'd0;
                if (is_flag || is_abort) begin
                    ln_keep    <= '0;
                    flag_seen  <= is_flag;
                    abort_seen <= is_abort;
                end else begin
                    d_valid <= ln_keep[LINE-1];
                    d_bit   <= ln_bit[LINE-1];
                    ln_bit  <= {ln_bit[LINE-2:0], bit_in};
                    ln_keep <= {ln_keep[LINE-2:0], !is_stuff};
                end
            end
        end
    end
endmodule

// File: rtl/hdlc_rx_crc.sv
// Bit-serial reflected CRC register. It is cleared to INIT on clear and
// advanced by one bit on bit_vld.
// Assumes clear and bit_vld are never asserted in the same cycle.
module hdlc_rx_crc #(
    parameter int unsigned  W    = 16,
    parameter logic [W-1:0] POLY = '0,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         bit_vld,
    input  logic         bit_in,
    output logic [W-1:0] crc
);
    // shift one LSB-first bit through the reflected polynomial
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            crc <= INIT;
        else if (bit_vld)
            crc <= (crc >> 1) ^ (((crc[0] ^ bit_in) == 1'b1) ? POLY : '0);
    end
endmodule

// File: rtl/hdlc_rx_deframer.sv
// HDLC receive deframer top. It packs destuffed bits into bytes, withholds
// the FCS bytes plus one so that the last payload byte can carry the end
// status, checks the CRC residue and the payload length, and reports aborts.
// Assumes crc32_sel, min_len and max_len are stable while a frame is open.
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic             crc32_sel,
    input  logic [LEN_W-1:0] min_len,
    input  logic [LEN_W-1:0] max_len,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof,
    output logic [2:0]       out_err
);
    localparam int unsigned HOLD_MAX = 5;
    localparam int unsigned HW       = $clog2(HOLD_MAX + 1);

    logic             d_valid, d_bit, flag_seen, abort_seen;
    logic             in_frame, sof_pend;
    logic [2:0]       bit_cnt;
    logic [7:0]       shreg, new_byte;
    logic [7:0]       hold [HOLD_MAX];
    logic [HW-1:0]    held, hold_len, last_idx, old_idx;
    logic [LEN_W-1:0] total, fcs_len, data_len;
    logic [15:0]      crc16;
    logic [31:0]      crc32;
    logic             crc_ok, len_bad, bit_go;
    rx_status_e       close_st;

    hdlc_rx_destuff u_destuff (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .d_valid(d_valid), .d_bit(d_bit),
        .flag_seen(flag_seen), .abort_seen(abort_seen)
    );

    hdlc_rx_crc #(.W(16), .POLY(CCITT_POLY), .INIT(16'hFFFF)) u_crc16 (
        .clk(clk), .rst_n(rst_n), .clear(flag_seen || abort_seen),
        .bit_vld(bit_go), .bit_in(d_bit), .crc(crc16)
    );

    hdlc_rx_crc #(.W(32), .POLY(C32_POLY), .INIT(32'hFFFFFFFF)) u_crc32 (
        .clk(clk), .rst_n(rst_n), .clear(flag_seen || abort_seen),
        .bit_vld(bit_go), .bit_in(d_bit), .crc(crc32)
    );

    // per-cycle decode of FCS size, residue check and closing status
    always_comb begin
        bit_go   = d_valid && in_frame;
        hold_len = crc32_sel ? HW'(HOLD_MAX) : HW'(3);
        last_idx = hold_len - HW'(1);
        old_idx  = held - HW'(1);
        fcs_len  = crc32_sel ? LEN_W'(4) : LEN_W'(2);
        data_len = total - fcs_len;
        new_byte = {d_bit, shreg[7:1]};
        crc_ok   = crc32_sel ? (crc32 == C32_GOOD) : (crc16 == CCITT_GOOD);
        len_bad  = (data_len < min_len) || (data_len > max_len);
        if (bit_cnt != 3'd0) close_st = ST_ALIGN;
        else if (!crc_ok)    close_st = ST_CRC;
        else if (len_bad)    close_st = ST_LEN;
        else                 close_st = ST_OK;
    end

    // frame state, byte packing, withheld bytes and output strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame  <= 1'b0;
            sof_pend  <= 1'b1;
            bit_cnt   <= '0;
            shreg     <= '0;
            held      <= '0;
            total     <= '0;
            for (int i = 0; i < HOLD_MAX; i++) hold[i] <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_err   <= ST_OK;
        end else begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_err   <= ST_OK;
            if (flag_seen || abort_seen) begin
                if (flag_seen && in_frame && held == hold_len) begin
                    out_valid <= 1'b1;
                    out_data  <= hold[last_idx];
                    out_sof   <= sof_pend;
                    out_eof   <= 1'b1;
                    out_err   <= close_st;
                end else if (abort_seen && in_frame && held != '0) begin
                    out_valid <= 1'b1;
                    out_data  <= hold[old_idx];
                    out_sof   <= sof_pend;
                    out_eof   <= 1'b1;
                    out_err   <= ST_ABORT;
                end
                in_frame <= flag_seen;
                sof_pend <= 1'b1;
                bit_cnt  <= '0;
                held     <= '0;
                total    <= '0;
            end else if (bit_go) begin
                shreg   <= new_byte;
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    hold[0] <= new_byte;
                    for (int i = 1; i < HOLD_MAX; i++) hold[i] <= hold[i-1];
                    if (total != '1) total <= total + LEN_W'(1);
                    if (held >= hold_len) begin
                        out_valid <= 1'b1;
                        out_data  <= hold[last_idx];
                        out_sof   <= sof_pend;
                        sof_pend  <= 1'b0;
                    end else begin
                        held <= held + HW'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
// Protocol checker for the deframer outputs, attached by bind.
// Tracks whether a frame is open on the output side.
module hdlc_rx_deframer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       out_valid,
    input logic       out_sof,
    input logic       out_eof,
    input logic [2:0] out_err
);
    logic in_pkt;

    // output-side frame open flag
    always_ff @(posedge clk) begin
        if (!rst_n)         in_pkt <= 1'b0;
        else if (out_valid) in_pkt <= !out_eof;
    end

    assert_eof_with_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_valid);
    assert_sof_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sof) |-> !in_pkt);
    assert_body_inside_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sof) |-> in_pkt);
    assert_err_on_eof_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_err != 3'd0) |-> (out_valid && out_eof));
    assert_err_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_err <= 3'd4));
    assert_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(bit_en, 2));
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .out_valid(out_valid),
    .out_sof(out_sof), .out_eof(out_eof), .out_err(out_err)
);

// File: tb/test_hdlc_rx_deframer.sv
module test_hdlc_rx_deframer;
    logic        clk = 1'b0;
    logic        rst_n, bit_en, bit_in, crc32_sel;
    logic [15:0] min_len, max_len;
    logic        out_valid, out_sof, out_eof;
    logic [7:0]  out_data;
    logic [2:0]  out_err;

    always #5 clk = ~clk;

    hdlc_rx_deframer i_hdlc_rx_deframer (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .crc32_sel(crc32_sel), .min_len(min_len), .max_len(max_len),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .out_eof(out_eof), .out_err(out_err)
    );

    typedef struct packed { bit v; bit [7:0] d; bit s; bit e; bit [2:0] er; } ev_t;

    int    vectors = 0, fails = 0;
    string cur_req = "R1";
    ev_t   p1 = '0, p2 = '0;
    int    eof_cnt = 0, byte_cnt = 0;
    bit [2:0] last_err = 0;
    bit    gap_mode = 0;
    int    gap_ctr = 0;

    // behavioural receiver model state
    int        m_ones = 0, m_bcnt = 0;
    bit        m_in = 0;
    bit [7:0]  m_cur = 0;
    bit [7:0]  m_fb[$];
    bit        m_lb[$], m_lk[$];

    function automatic bit crc_good(bit w32);
        bit [31:0] c = w32 ? 32'hFFFFFFFF : 32'h0000FFFF;
        foreach (m_fb[k]) for (int i = 0; i < 8; i++) begin
            bit f = c[0] ^ m_fb[k][i];
            c = c >> 1;
            if (f) c ^= w32 ? 32'hEDB88320 : 32'h00008408;
        end
        return w32 ? (c == 32'hDEBB20E3) : (c[15:0] == 16'hF0B8);
    endfunction

    function automatic ev_t emit(int idx, bit eof, bit [2:0] er);
        ev_t r;
        r.v = 1; r.d = m_fb[idx]; r.s = (idx == 0); r.e = eof; r.er = er;
        return r;
    endfunction

    function automatic void new_frame(bit open);
        m_in = open; m_fb.delete(); m_bcnt = 0; m_cur = 0;
        m_lb.delete(); m_lk.delete();
    endfunction

    function automatic ev_t model_step(bit en, bit b, bit w32);
        ev_t r = '0;
        int hl = w32 ? 5 : 3;
        int fl = w32 ? 4 : 2;
        bit k = 1;
        if (!en) return r;
        if (b) begin
            m_ones++;
            if (m_ones >= 7) begin
                m_ones = 7;
                if (m_in && m_fb.size() > 0)
                    r = emit(m_fb.size() - ((m_fb.size() < hl) ? m_fb.size() : hl), 1, 3);
                new_frame(0);
                return r;
            end
        end else begin
            if (m_ones == 6) begin
                if (m_in && m_fb.size() >= hl) begin
                    bit [2:0] er = 0;
                    int len = m_fb.size() - fl;
                    if (m_bcnt != 0) er = 4;
                    else if (!crc_good(w32)) er = 1;
                    else if (len < int'(min_len) || len > int'(max_len)) er = 2;
                    r = emit(m_fb.size() - hl, 1, er);
                end
                new_frame(1);
                m_ones = 0;
                return r;
            end
            k = (m_ones != 5);
            m_ones = 0;
        end
        m_lb.push_back(b); m_lk.push_back(k);
        if (m_lb.size() > 7) begin
            bit pb = m_lb.pop_front();
            bit pk = m_lk.pop_front();
            if (pk && m_in) begin
                m_cur = {pb, m_cur[7:1]};
                m_bcnt++;
                if (m_bcnt == 8) begin
                    m_bcnt = 0;
                    m_fb.push_back(m_cur);
                    if (m_fb.size() > hl) r = emit(m_fb.size() - 1 - hl, 0, 0);
                end
            end
        end
        return r;
    endfunction

    // per-clock comparison of DUT outputs with the model (R13 timing)
    task automatic compare();
        vectors++;
        if (out_valid !== p2.v ||
            (p2.v && (out_data !== p2.d || out_sof !== p2.s ||
                      out_eof !== p2.e || out_err !== p2.er))) begin
            fails++;
            $display("FAIL %s/R13 cycle: got v=%0b d=%02h s=%0b e=%0b err=%0d exp v=%0b d=%02h s=%0b e=%0b err=%0d",
                     cur_req, out_valid, out_data, out_sof, out_eof, out_err,
                     p2.v, p2.d, p2.s, p2.e, p2.er);
        end
        if (out_valid) begin
            byte_cnt++;
            if (out_eof) begin eof_cnt++; last_err = out_err; end
        end
    endtask

    task automatic tick(bit en, bit b);
        @(negedge clk);
        compare();
        p2 = p1;
        bit_en = en; bit_in = b;
        p1 = model_step(en, b, crc32_sel);
    endtask

    task automatic send_bit(bit b);
        if (gap_mode) begin
            gap_ctr++;
            if (gap_ctr % 3 == 0) tick(0, 1);
        end
        tick(1, b);
    endtask

    task automatic send_flag();
        send_bit(0);
        for (int i = 0; i < 6; i++) send_bit(1);
        send_bit(0);
    endtask

    task automatic send_bytes(bit [7:0] q[$], int extra);
        int ones = 0;
        for (int n = 0; n < q.size() * 8 + extra; n++) begin
            bit b = (n < q.size() * 8) ? q[n / 8][n % 8] : bit'(n % 2);
            send_bit(b);
            ones = b ? ones + 1 : 0;
            if (ones == 5) begin send_bit(0); ones = 0; end
        end
    endtask

    task automatic add_fcs(ref bit [7:0] q[$], input bit w32, input bit bad);
        bit [31:0] c = w32 ? 32'hFFFFFFFF : 32'h0000FFFF;
        foreach (q[k]) for (int i = 0; i < 8; i++) begin
            bit f = c[0] ^ q[k][i];
            c = c >> 1;
            if (f) c ^= w32 ? 32'hEDB88320 : 32'h00008408;
        end
        c = ~c;
        if (bad) c[3] = ~c[3];
        for (int i = 0; i < (w32 ? 4 : 2); i++) q.push_back(c[8*i +: 8]);
    endtask

    task automatic frame(bit [7:0] d[$], bit w32, bit bad, int extra);
        bit [7:0] q[$] = d;
        add_fcs(q, w32, bad);
        send_bytes(q, extra);
        send_flag();
        send_flag();
    endtask

    task automatic settle();
        for (int i = 0; i < 4; i++) tick(0, 0);
    endtask

    task automatic expect_res(string req, int eofs, int err, int bytes);
        vectors++;
        if (eof_cnt != eofs || (eofs > 0 && last_err != err) ||
            (bytes >= 0 && byte_cnt != bytes)) begin
            fails++;
            $display("FAIL %s: got eofs=%0d err=%0d bytes=%0d exp eofs=%0d err=%0d bytes=%0d",
                     req, eof_cnt, last_err, byte_cnt, eofs, err, bytes);
        end
        eof_cnt = 0; byte_cnt = 0; last_err = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst_n = 0; bit_en = 0; bit_in = 0; crc32_sel = 0;
        min_len = 1; max_len = 64;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state of the outputs
        cur_req = "R1";
        vectors++;
        if (out_valid !== 0 || out_sof !== 0 || out_eof !== 0 || out_err !== 0) begin
            fails++;
            $display("FAIL R1: got v=%0b s=%0b e=%0b err=%0d exp all 0",
                     out_valid, out_sof, out_eof, out_err);
        end
        // R2: hunting before the first flag yields nothing
        cur_req = "R2";
        send_bytes('{8'h55, 8'h33, 8'h0F, 8'h9C, 8'h12}, 0);
        settle();
        expect_res("R2", 0, 0, 0);
        send_flag();
        // R3 R4 R5 R6: good 16-bit frame with stuffing-forcing bytes
        cur_req = "R3/R4";
        frame('{8'h7E, 8'hFF, 8'h01, 8'hF8}, 0, 0, 0);
        settle();
        expect_res("R4", 1, 0, 4);
        // R5: single payload byte carries both markers
        cur_req = "R5";
        frame('{8'hA5}, 0, 0, 0);
        settle();
        expect_res("R5", 1, 0, 1);
        // R6: corrupted 16-bit FCS
        cur_req = "R6";
        frame('{8'h10, 8'h20, 8'h30}, 0, 1, 0);
        settle();
        expect_res("R6", 1, 1, 3);
        // R7: 32-bit FCS, good then bad
        cur_req = "R7";
        crc32_sel = 1;
        frame('{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'hFF}, 1, 0, 0);
        settle();
        expect_res("R7", 1, 0, 5);
        frame('{8'h01, 8'h02}, 1, 1, 0);
        settle();
        expect_res("R7", 1, 1, 2);
        crc32_sel = 0;
        send_flag();
        // R8: length window, short then long, then CRC beats length
        cur_req = "R8";
        min_len = 4; max_len = 6;
        frame('{8'h11, 8'h22, 8'h33}, 0, 0, 0);
        settle();
        expect_res("R8", 1, 2, 3);
        frame('{8'h1, 8'h2, 8'h3, 8'h4, 8'h5, 8'h6, 8'h7, 8'h8}, 0, 0, 0);
        settle();
        expect_res("R8", 1, 2, 8);
        frame('{8'h1, 8'h2}, 0, 1, 0);
        settle();
        expect_res("R8", 1, 1, 2);
        min_len = 1; max_len = 64;
        // R9: abort in the middle of a frame, then hunt
        cur_req = "R9";
        send_bytes('{8'h21, 8'h43, 8'h65, 8'h07, 8'h09, 8'h0B}, 0);
        for (int i = 0; i < 9; i++) send_bit(1);
        send_bytes('{8'h12, 8'h34, 8'h56, 8'h78}, 0);
        send_flag();
        settle();
        expect_res("R9", 1, 3, -1);
        // R10: non-octet frame
        cur_req = "R10";
        frame('{8'h5A, 8'h6B, 8'h7C}, 0, 0, 3);
        settle();
        expect_res("R10", 1, 4, 3);
        // R11: fragments too short are silent
        cur_req = "R11";
        send_bytes('{8'h12, 8'h34}, 0);
        send_flag();
        crc32_sel = 1;
        send_flag();
        send_bytes('{8'h12, 8'h34, 8'h56, 8'h78}, 0);
        send_flag();
        settle();
        expect_res("R11", 0, 0, 0);
        crc32_sel = 0;
        send_flag();
        // R12: shared flag between frames, with idle bit_en gaps
        cur_req = "R12";
        gap_mode = 1;
        begin
            bit [7:0] a[$] = '{8'hC3, 8'h3C, 8'h7E};
            bit [7:0] b[$] = '{8'hFF, 8'h00};
            add_fcs(a, 0, 0);
            add_fcs(b, 0, 0);
            send_bytes(a, 0);
            send_flag();
            send_bytes(b, 0);
            send_flag();
        end
        gap_mode = 0;
        settle();
        expect_res("R12", 2, 0, 5);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule